// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave for a Clock Register and RAM Space

This block sits between a host bus that shares eight pins for address and data and a 128-byte space. The space holds the clock and control bytes of a real-time clock at offsets 0x00 to 0x0D and 114 bytes of general-purpose RAM at 0x0E to 0x7F. The host first presents an address and pulses the address strobe. It then reads with a low read strobe or writes with a low write strobe, with the select line held low. The block samples all bus pins in its own clock domain and finds strobe edges by comparing each sample with the previous one. It drives the data pins only while a qualified read is in progress.

A three-state controller sequences each access. From `BUS_IDLE`, *start-read* moves to `BUS_READ` and *start-write* moves to `BUS_WRITE`. From `BUS_READ`, *end-read* returns to `BUS_IDLE`. From `BUS_WRITE`, *commit* returns to `BUS_IDLE` and writes the byte; *abort* also returns to `BUS_IDLE` but drops the write. An access is allowed only while the select line is low, power is reported good and the host reset input is high.

Per-register rules decide what a host write may change. The status bytes at 0x0C and 0x0D are supplied from outside and cannot be written. Bit 7 of 0x00 and bit 7 of 0x0A cannot be written by the host. The timekeeper writes whole clock bytes through a side port. A clear input fills the RAM with ones. A one-cycle pulse tells the interrupt logic that the host has started to read 0x0C.

Top module: `rtc_mbus_slave`

## Requirements
- R1: A sample with `addr_strobe` low that follows a sample with it high loads `ad_in[6:0]` into the address register. This happens whatever `bus_sel_n` is, and `ad_in[7]` is ignored.
- R2: Suppose `bus_rd_n` is sampled low while access is allowed (`bus_sel_n` low, `power_good` high, `host_reset_n` high). `ad_oe` is then high from the next cycle, and `ad_out` carries the byte at the latched address. `ad_oe` falls in the cycle after `bus_rd_n` is sampled high or access is lost.
- R3: A write takes the `ad_in` value of the last sample that had `bus_wr_n` low. It stores that value at the latched address on the edge that first samples `bus_wr_n` high with access still allowed.
- R4: With `bus_sel_n` high, a strobe neither drives `ad_oe` nor changes any byte.
- R5: Host writes to 0x0C and 0x0D are ignored. Reads of those bytes return `stat_c_in` and `stat_d_in`. Reads of 0x0A return `uip_in` in bit 7, and a host write leaves the stored bit 7 of 0x0A and of 0x00 unchanged.
- R6: With `power_good` low, no read drives the bus. A write whose commit edge sees `power_good` low is aborted and stores nothing.
- R7: With `host_reset_n` low, no access takes place. Each cycle it stays low clears bits 6..3 of byte 0x0B (the enables, seen on `cfg_b`). All other bytes keep their values.
- R8: Each edge with `ram_clear` high sets bytes 0x0E..0x7F to 0xFF, even against a host write in the same cycle. Bytes 0x00..0x0D are left unchanged.
- R9: `rd_c_stb` is high for exactly one cycle, the first `ad_oe` cycle of a read of 0x0C. It stays low for reads of any other address.
- R10: `tk_wr_en` writes all eight bits of `tk_wr_data` into core byte `tk_wr_addr` (0x00..0x0B) on the next edge. A host commit to the same byte on the same edge takes priority.
- R11: After `rst_n`, `ad_oe` and `rd_c_stb` are low and every byte of the space reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ad_in | input | 8 | Sampled value of the shared address/data pins |
| ad_out | output | 8 | Read data for the shared pins (0 when not driving) |
| ad_oe | output | 1 | Output enable for the shared pins |
| addr_strobe | input | 1 | Address strobe; its falling edge latches the address |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_sel_n | input | 1 | Active-low select |
| host_reset_n | input | 1 | Active-low host reset; blocks access and clears the enables |
| power_good | input | 1 | High while supply is in range; low forces the select inactive |
| ram_clear | input | 1 | Fills the user RAM with 0xFF |
| tk_wr_en | input | 1 | Timekeeper write enable |
| tk_wr_addr | input | 4 | Timekeeper target byte (0x00..0x0B) |
| tk_wr_data | input | 8 | Timekeeper write data |
| uip_in | input | 1 | Update-in-progress flag returned as bit 7 of 0x0A |
| stat_c_in | input | 8 | Value returned for reads of 0x0C |
| stat_d_in | input | 8 | Value returned for reads of 0x0D |
| cfg_b | output | 8 | Current content of byte 0x0B |
| rd_c_stb | output | 1 | One-cycle pulse when a read of 0x0C begins |

## Verification
Every result in this block is due one rising edge after the sample that causes it. The address is usable after the edge that sees the strobe low. `ad_oe` and the read data appear after the edge that sees the read strobe low, and `ad_oe` clears after the edge that sees it high. A write becomes readable after the edge that sees the write strobe high, and clear or timekeeper writes land on the edge that samples them. The bench changes inputs 2 ns after a rising edge. A behavioural model advances on the same rising edge, and `ad_oe`, `ad_out`, `rd_c_stb` and `cfg_b` are compared at every falling edge. Directed reads check fixed constants for each requirement in the cycle the data is first driven.

// File: rtl/rtc_mbus_pkg.sv
package rtc_mbus_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Byte offsets whose behaviour neighbours rely on
    localparam int IDX_SECONDS = 0;
    localparam int IDX_CTRL_A  = 10;
    localparam int IDX_MODE_B  = 11;
    localparam int IDX_STAT_C  = 12;
    localparam int IDX_STAT_D  = 13;

    // Enable bits in 0x0B cleared by the host reset input
    localparam byte_t MODE_B_ENABLES = 8'h78;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_state_e;

    // Bits a host write may change in each core byte
    function automatic byte_t host_write_mask(input int idx);
        byte_t m;
        m = '1;
        if (idx == IDX_SECONDS || idx == IDX_CTRL_A)
            m[BYTE_W-1] = 1'b0;
        if (idx == IDX_STAT_C || idx == IDX_STAT_D)
            m = '0;
        return m;
    endfunction

endpackage

// File: rtl/rtc_mbus_addr_latch.sv
module rtc_mbus_addr_latch #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    logic strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            strobe_q <= strobe;
            if (strobe_q && !strobe)
                addr_q <= addr_in;
        end
    end

endmodule

// File: rtl/rtc_mbus_fsm.sv
module rtc_mbus_fsm
    import rtc_mbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  access_ok,
    input  logic  rd_n,
    input  logic  wr_n,
    input  logic  sel_stat_c,
    input  byte_t bus_in,
    output logic  drive_en,
    output logic  commit,
    output byte_t wdata_q,
    output logic  rd_c_stb
);

    bus_state_e state_q, state_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (access_ok && !rd_n)
                    state_d = BUS_READ;        // start-read
                else if (access_ok && !wr_n)
                    state_d = BUS_WRITE;       // start-write
            end
            BUS_READ: begin
                if (!access_ok || rd_n)
                    state_d = BUS_IDLE;        // end-read
            end
            BUS_WRITE: begin
                if (!access_ok || wr_n)
                    state_d = BUS_IDLE;        // commit or abort
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BUS_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        drive_en = (state_q == BUS_READ);
        commit   = (state_q == BUS_WRITE) && access_ok && wr_n;
    end

    // write data capture and read-of-C pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q  <= '0;
            rd_c_stb <= 1'b0;
        end else begin
            if ((state_q == BUS_IDLE && state_d == BUS_WRITE) ||
                (state_q == BUS_WRITE && !wr_n))
                wdata_q <= bus_in;
            rd_c_stb <= (state_q == BUS_IDLE) && (state_d == BUS_READ) && sel_stat_c;
        end
    end

endmodule

// File: rtl/rtc_mbus_store.sv
module rtc_mbus_store
    import rtc_mbus_pkg::*;
#(
    parameter  int ADDR_W     = 7,
    parameter  int CORE_BYTES = 14,
    localparam int CIDX_W     = $clog2(CORE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  byte_t             host_wdata,
    input  logic              tk_we,
    input  logic [CIDX_W-1:0] tk_addr,
    input  byte_t             tk_data,
    input  logic              ram_clear,
    input  logic              hold_reset,
    input  logic              uip_in,
    input  byte_t             stat_c_in,
    input  byte_t             stat_d_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             rd_data,
    output byte_t             cfg_b
);

    localparam int SPACE       = 2 ** ADDR_W;
    localparam int RAM_BYTES   = SPACE - CORE_BYTES;
    localparam int CORE_STORED = IDX_STAT_C;

    byte_t core_q [CORE_STORED];
    byte_t core_d [CORE_STORED];
    byte_t ram_q  [RAM_BYTES];
    byte_t ram_d  [RAM_BYTES];

    always_comb begin
        for (int i = 0; i < CORE_STORED; i++) begin
            core_d[i] = core_q[i];
            if (tk_we && int'(tk_addr) == i)
                core_d[i] = tk_data;
            if (host_we && int'(host_addr) == i)
                core_d[i] = (core_q[i] & ~host_write_mask(i)) |
                            (host_wdata & host_write_mask(i));
            if (hold_reset && i == IDX_MODE_B)
                core_d[i] = core_d[i] & ~MODE_B_ENABLES;
        end
        for (int j = 0; j < RAM_BYTES; j++) begin
            ram_d[j] = ram_q[j];
            if (ram_clear)
                ram_d[j] = '1;
            else if (host_we && int'(host_addr) == j + CORE_BYTES)
                ram_d[j] = host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CORE_STORED; i++) core_q[i] <= '0;
            for (int j = 0; j < RAM_BYTES; j++)   ram_q[j]  <= '0;
        end else begin
            for (int i = 0; i < CORE_STORED; i++) core_q[i] <= core_d[i];
            for (int j = 0; j < RAM_BYTES; j++)   ram_q[j]  <= ram_d[j];
        end
    end

    // read multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(CORE_STORED)) begin
            rd_data = core_q[rd_addr[CIDX_W-1:0]];
            if (rd_addr == ADDR_W'(IDX_CTRL_A))
                rd_data[BYTE_W-1] = uip_in;
        end else if (rd_addr == ADDR_W'(IDX_STAT_C)) begin
            rd_data = stat_c_in;
        end else if (rd_addr == ADDR_W'(IDX_STAT_D)) begin
            rd_data = stat_d_in;
        end else begin
            rd_data = ram_q[rd_addr - ADDR_W'(CORE_BYTES)];
        end
    end

    assign cfg_b = core_q[IDX_MODE_B];

endmodule

// File: rtl/rtc_mbus_slave.sv
module rtc_mbus_slave
    import rtc_mbus_pkg::*;
#(
    parameter  int ADDR_W     = 7,
    parameter  int CORE_BYTES = 14,
    localparam int CIDX_W     = $clog2(CORE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ad_in,
    output logic [7:0]        ad_out,
    output logic              ad_oe,
    input  logic              addr_strobe,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              bus_sel_n,
    input  logic              host_reset_n,
    input  logic              power_good,
    input  logic              ram_clear,
    input  logic              tk_wr_en,
    input  logic [CIDX_W-1:0] tk_wr_addr,
    input  logic [7:0]        tk_wr_data,
    input  logic              uip_in,
    input  logic [7:0]        stat_c_in,
    input  logic [7:0]        stat_d_in,
    output logic [7:0]        cfg_b,
    output logic              rd_c_stb
);

    logic [ADDR_W-1:0] addr_q;
    logic              access_ok;
    logic              drive_en;
    logic              commit;
    byte_t             wdata_q;
    byte_t             rd_data;

    // power failure or host reset force the select inactive
    assign access_ok = !bus_sel_n && power_good && host_reset_n;

    rtc_mbus_addr_latch #(.ADDR_W(ADDR_W)) u_alat (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (addr_strobe),
        .addr_in (ad_in[ADDR_W-1:0]),
        .addr_q  (addr_q)
    );

    rtc_mbus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .access_ok  (access_ok),
        .rd_n       (bus_rd_n),
        .wr_n       (bus_wr_n),
        .sel_stat_c (addr_q == ADDR_W'(IDX_STAT_C)),
        .bus_in     (ad_in),
        .drive_en   (drive_en),
        .commit     (commit),
        .wdata_q    (wdata_q),
        .rd_c_stb   (rd_c_stb)
    );

    rtc_mbus_store #(.ADDR_W(ADDR_W), .CORE_BYTES(CORE_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (commit),
        .host_addr  (addr_q),
        .host_wdata (wdata_q),
        .tk_we      (tk_wr_en),
        .tk_addr    (tk_wr_addr),
        .tk_data    (tk_wr_data),
        .ram_clear  (ram_clear),
        .hold_reset (!host_reset_n),
        .uip_in     (uip_in),
        .stat_c_in  (stat_c_in),
        .stat_d_in  (stat_d_in),
        .rd_addr    (addr_q),
        .rd_data    (rd_data),
        .cfg_b      (cfg_b)
    );

    assign ad_oe  = drive_en;
    assign ad_out = drive_en ? rd_data : '0;

endmodule

// File: rtl/rtc_mbus_slave_chk.sv
module rtc_mbus_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ad_oe,
    input logic       bus_rd_n,
    input logic       bus_sel_n,
    input logic       power_good,
    input logic       host_reset_n,
    input logic [7:0] cfg_b,
    input logic       rd_c_stb
);

    // R2/R4: the bus is only driven after a qualified read strobe
    assert_oe_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> $past(!bus_sel_n && !bus_rd_n && power_good && host_reset_n));

    assert_oe_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && bus_rd_n) |=> !ad_oe);

    assert_pwr_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |=> !ad_oe);

    assert_reset_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_reset_n |=> (cfg_b[6:3] == 4'b0000));

    assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c_stb |=> !rd_c_stb);

    assert_stb_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c_stb |-> ad_oe);

endmodule

bind rtc_mbus_slave rtc_mbus_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ad_oe        (ad_oe),
    .bus_rd_n     (bus_rd_n),
    .bus_sel_n    (bus_sel_n),
    .power_good   (power_good),
    .host_reset_n (host_reset_n),
    .cfg_b        (cfg_b),
    .rd_c_stb     (rd_c_stb)
);

// File: tb/rtc_mbus_slave_test.sv
`timescale 1ns/1ps
module rtc_mbus_slave_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       addr_strobe = 1'b0;
    logic       bus_rd_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic       bus_sel_n = 1'b1;
    logic       host_reset_n = 1'b1;
    logic       power_good = 1'b1;
    logic       ram_clear = 1'b0;
    logic       tk_wr_en = 1'b0;
    logic [3:0] tk_wr_addr = 4'h0;
    logic [7:0] tk_wr_data = 8'h00;
    logic       uip_in = 1'b0;
    logic [7:0] stat_c_in = 8'h3C;
    logic [7:0] stat_d_in = 8'h80;
    logic [7:0] cfg_b;
    logic       rd_c_stb;

    always #5 clk = ~clk;

    rtc_mbus_slave uut (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_strobe(addr_strobe), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_sel_n(bus_sel_n), .host_reset_n(host_reset_n), .power_good(power_good),
        .ram_clear(ram_clear), .tk_wr_en(tk_wr_en), .tk_wr_addr(tk_wr_addr),
        .tk_wr_data(tk_wr_data), .uip_in(uip_in), .stat_c_in(stat_c_in),
        .stat_d_in(stat_d_in), .cfg_b(cfg_b), .rd_c_stb(rd_c_stb)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    stb_seen = 0;
    bit    done = 0;
    string cur_req = "R11";

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] mem [128];
    int         m_phase;      // 0 idle, 1 reading, 2 writing
    logic [6:0] m_addr;
    logic [7:0] m_wd;
    bit         m_stb;
    bit         m_as_prev;

    function automatic logic [7:0] model_read(input logic [6:0] a);
        if (a == 7'h0C) return stat_c_in;
        if (a == 7'h0D) return stat_d_in;
        if (a == 7'h0A) return {uip_in, mem[10][6:0]};
        return mem[a];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] = 8'h00;
            m_phase = 0; m_addr = '0; m_wd = '0; m_stb = 0; m_as_prev = 0;
        end else begin
            bit acc;
            bit nstb;
            acc  = !bus_sel_n && power_good && host_reset_n;
            nstb = 0;
            if (tk_wr_en && tk_wr_addr < 4'd12) mem[tk_wr_addr] = tk_wr_data;
            if (m_phase == 2 && acc && bus_wr_n) begin
                if (m_addr == 7'h00 || m_addr == 7'h0A)
                    mem[m_addr] = {mem[m_addr][7], m_wd[6:0]};
                else if (m_addr != 7'h0C && m_addr != 7'h0D)
                    mem[m_addr] = m_wd;
            end
            if (!host_reset_n) mem[11] = mem[11] & 8'h87;
            if (ram_clear) for (int i = 14; i < 128; i++) mem[i] = 8'hFF;
            case (m_phase)
                0: if (acc && !bus_rd_n) begin m_phase = 1; nstb = (m_addr == 7'h0C); end
                   else if (acc && !bus_wr_n) begin m_phase = 2; m_wd = ad_in; end
                1: if (!acc || bus_rd_n) m_phase = 0;
                default: if (!acc || bus_wr_n) m_phase = 0; else m_wd = ad_in;
            endcase
            m_stb = nstb;
            if (m_as_prev && !addr_strobe) m_addr = ad_in[6:0];
            m_as_prev = addr_strobe;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "oe vs model", {7'b0, ad_oe}, {7'b0, (m_phase == 1)});
            if (m_phase == 1) chk(cur_req, "read data vs model", ad_out, model_read(m_addr));
            chk(cur_req, "c-strobe vs model", {7'b0, rd_c_stb}, {7'b0, m_stb});
            chk(cur_req, "cfg_b vs model", cfg_b, mem[11]);
            if (rd_c_stb) stb_seen++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic latch(input logic [7:0] a);
        ad_in = a; addr_strobe = 1'b1; step(1);
        addr_strobe = 1'b0; step(1);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] v, output logic oe);
        latch(a);
        bus_sel_n = 1'b0; bus_rd_n = 1'b0; step(2);
        v = ad_out; oe = ad_oe;
        bus_rd_n = 1'b1; step(1);
        bus_sel_n = 1'b1; step(1);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        latch(a);
        ad_in = d; bus_sel_n = 1'b0; bus_wr_n = 1'b0; step(2);
        bus_wr_n = 1'b1; step(1);
        bus_sel_n = 1'b1; step(1);
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v; logic oe;
        bus_read(a, v, oe);
        chk(req, $sformatf("oe on read %h", a), {7'b0, oe}, 8'h01);
        chk(req, $sformatf("data at %h", a), v, exp);
    endtask

    task automatic tk_write(input logic [3:0] a, input logic [7:0] d);
        tk_wr_en = 1'b1; tk_wr_addr = a; tk_wr_data = d; step(1);
        tk_wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic oe;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R11 reset state
        cur_req = "R11";
        chk("R11", "oe after reset", {7'b0, ad_oe}, 8'h00);
        chk("R11", "c-strobe after reset", {7'b0, rd_c_stb}, 8'h00);
        chk("R11", "cfg_b after reset", cfg_b, 8'h00);
        expect_rd("R11", 8'h20, 8'h00);
        expect_rd("R11", 8'h05, 8'h00);

        // R3 writes and read-back
        cur_req = "R3";
        bus_write(8'h20, 8'h5A);
        bus_write(8'h7F, 8'hC3);
        bus_write(8'h03, 8'h12);
        expect_rd("R3", 8'h20, 8'h5A);
        expect_rd("R3", 8'h7F, 8'hC3);
        expect_rd("R3", 8'h03, 8'h12);

        // R2 drive window
        cur_req = "R2";
        latch(8'h20);
        bus_sel_n = 1'b0; bus_rd_n = 1'b0;
        chk("R2", "oe before edge", {7'b0, ad_oe}, 8'h00);
        step(1);
        chk("R2", "oe one cycle after strobe", {7'b0, ad_oe}, 8'h01);
        chk("R2", "data while driving", ad_out, 8'h5A);
        bus_rd_n = 1'b1; step(1);
        chk("R2", "oe released", {7'b0, ad_oe}, 8'h00);
        bus_sel_n = 1'b1; step(1);

        // R1 address latched without select, bit 7 ignored
        cur_req = "R1";
        latch(8'hFF);
        latch(8'hA0);
        bus_sel_n = 1'b0; bus_rd_n = 1'b0; step(2);
        chk("R1", "latched addr 0x20 from 0xA0", ad_out, 8'h5A);
        bus_rd_n = 1'b1; step(1); bus_sel_n = 1'b1; step(1);

        // R4 select high: no drive, no write
        cur_req = "R4";
        latch(8'h20);
        ad_in = 8'h11; bus_wr_n = 1'b0; step(2); bus_wr_n = 1'b1; step(2);
        bus_rd_n = 1'b0; step(2);
        chk("R4", "oe with select high", {7'b0, ad_oe}, 8'h00);
        bus_rd_n = 1'b1; step(1);
        expect_rd("R4", 8'h20, 8'h5A);

        // R5 read-only bytes and bits
        cur_req = "R5";
        bus_write(8'h0C, 8'hFF);
        bus_write(8'h0D, 8'h00);
        expect_rd("R5", 8'h0C, 8'h3C);
        expect_rd("R5", 8'h0D, 8'h80);
        bus_write(8'h0A, 8'hFF);
        expect_rd("R5", 8'h0A, 8'h7F);
        uip_in = 1'b1;
        expect_rd("R5", 8'h0A, 8'hFF);
        uip_in = 1'b0;
        bus_write(8'h00, 8'hFF);
        expect_rd("R5", 8'h00, 8'h7F);

        // R6 power failure
        cur_req = "R6";
        power_good = 1'b0;
        bus_read(8'h20, v, oe);
        chk("R6", "oe with power low", {7'b0, oe}, 8'h00);
        bus_write(8'h21, 8'h66);
        power_good = 1'b1;
        expect_rd("R6", 8'h21, 8'h00);
        latch(8'h22);
        ad_in = 8'h77; bus_sel_n = 1'b0; bus_wr_n = 1'b0; step(2);
        power_good = 1'b0; step(1);
        bus_wr_n = 1'b1; step(1);
        power_good = 1'b1; bus_sel_n = 1'b1; step(1);
        expect_rd("R6", 8'h22, 8'h00);

        // R7 host reset
        cur_req = "R7";
        bus_write(8'h0B, 8'hFF);
        chk("R7", "cfg_b written", cfg_b, 8'hFF);
        host_reset_n = 1'b0; step(1);
        chk("R7", "enables cleared", cfg_b, 8'h87);
        bus_read(8'h20, v, oe);
        chk("R7", "oe during host reset", {7'b0, oe}, 8'h00);
        host_reset_n = 1'b1; step(1);
        expect_rd("R7", 8'h0B, 8'h87);
        expect_rd("R7", 8'h20, 8'h5A);

        // R9 strobe on read of C only
        cur_req = "R9";
        stb_seen = 0;
        expect_rd("R9", 8'h0C, 8'h3C);
        chk("R9", "pulses for read of 0x0C", 8'(stb_seen), 8'h01);
        stb_seen = 0;
        expect_rd("R9", 8'h20, 8'h5A);
        chk("R9", "pulses for read of 0x20", 8'(stb_seen), 8'h00);

        // R10 timekeeper port
        cur_req = "R10";
        tk_write(4'h5, 8'h99);
        expect_rd("R10", 8'h05, 8'h99);
        tk_write(4'h0, 8'hAA);
        expect_rd("R10", 8'h00, 8'hAA);
        latch(8'h04);
        ad_in = 8'h44; bus_sel_n = 1'b0; bus_wr_n = 1'b0; step(2);
        bus_wr_n = 1'b1; tk_wr_en = 1'b1; tk_wr_addr = 4'h4; tk_wr_data = 8'h77; step(1);
        tk_wr_en = 1'b0; bus_sel_n = 1'b1; step(1);
        expect_rd("R10", 8'h04, 8'h44);

        // R8 RAM clear
        cur_req = "R8";
        ram_clear = 1'b1; step(1); ram_clear = 1'b0; step(1);
        expect_rd("R8", 8'h20, 8'hFF);
        expect_rd("R8", 8'h0E, 8'hFF);
        expect_rd("R8", 8'h7F, 8'hFF);
        expect_rd("R8", 8'h03, 8'h12);
        latch(8'h30);
        ad_in = 8'h01; bus_sel_n = 1'b0; bus_wr_n = 1'b0; step(2);
        bus_wr_n = 1'b1; ram_clear = 1'b1; step(1);
        ram_clear = 1'b0; bus_sel_n = 1'b1; step(1);
        expect_rd("R8", 8'h30, 8'hFF);

        step(2);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule